// File: doc/BRIEF.md
# Factorial Coprocessor with Interrupt Register

This block is a small memory-mapped peripheral reached through a 32-bit word-access slave port. It returns a fixed identification word and has a liveness register that reads back the inverse of what was last written. Its main part is a multi-cycle factorial engine. Software writes an operand, watches a busy flag until it drops, then reads the result from the same location.

An interrupt status register gathers completion events. The factorial engine raises one bit when the interrupt enable is set, and other units on the chip can raise bits through a side input. Software sets bits through one address and clears them through another. A single level-sensitive interrupt line is high whenever any status bit is set.

Top module: `fact_copro`

## Requirements
- R1: A full-word read of offset 0x00 returns 0x010000ED.
- R2: A full-word read of offset 0x04 returns the bitwise complement of the last full-word value written to 0x04.
- R3: A full-word write to offset 0x08 while idle loads the operand and sets the busy flag (bit 0 of offset 0x20) from the next cycle; a write to 0x08 while busy is ignored.
- R4: When the job finishes, offset 0x08 reads the low 32 bits of operand × (operand−1) × … × 1, with operand 0 giving 1, and busy is clear; one multiply is done per clock.
- R5: Bit 7 of offset 0x20 is a writable interrupt enable that reads back; bit 0 (busy) ignores writes; all other bits read 0.
- R6: At completion with bit 7 set, bit 0 (value 0x1) of the interrupt status is set; with bit 7 clear it is left unchanged.
- R7: Offset 0x24 reads the interrupt status; a full-word write to 0x60 ORs the data into it, and a full-word write to 0x64 clears the bits that are set in the data.
- R8: The interrupt line is high exactly when the interrupt status is nonzero.
- R9: A write whose byte enables are not all four set is ignored; a read with partial byte enables, or a read of an unmapped offset, returns 0xFFFFFFFF.
- R10: Bits on the raise input (the DMA source uses bit 8, value 0x100) are ORed into the interrupt status at the next edge, and they win over a clear of the same bit in that cycle.
- R11: Reset clears the operand, the busy flag, the enable, the interrupt status and the liveness register, and drives the interrupt line low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_be | input | 4 | Byte enables; only 4'hF is a valid access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered, valid the cycle after a read request |
| ext_raise | input | 32 | Interrupt bits raised by other units |
| irq | output | 1 | Level-sensitive interrupt line |

## Verification
Read data comes from a register, so every read result is sampled just after the edge that accepts the request, and every register write is visible to a read issued in the next cycle. The busy flag is set at the edge that accepts the operand write, so a status read issued right after must already see bit 0. The result is due operand+1 edges later, or sooner once the running product wraps to zero, so the bench polls the status register with a bounded count instead of guessing the exact edge. Interrupt status and the line change at the edge that takes a set, clear or raise input, and they are checked one cycle later.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
   localparam int unsigned WORD_W = 32;
   localparam logic [WORD_W-1:0] ID_WORD = 32'h010000ED;

   localparam logic [7:0] OFS_ID    = 8'h00;
   localparam logic [7:0] OFS_LIVE  = 8'h04;
   localparam logic [7:0] OFS_OPND  = 8'h08;
   localparam logic [7:0] OFS_STAT  = 8'h20;
   localparam logic [7:0] OFS_IRQ   = 8'h24;
   localparam logic [7:0] OFS_SET   = 8'h60;
   localparam logic [7:0] OFS_CLR   = 8'h64;

   localparam int unsigned BUSY_BIT   = 0;
   localparam int unsigned EN_BIT     = 7;
   localparam int unsigned FACT_IRQ_BIT = 0;

   typedef enum logic [2:0] {
      RS_ID, RS_LIVE, RS_OPND, RS_STAT, RS_IRQ, RS_NONE
   } rd_sel_t;

   typedef struct packed {
      logic wr_live;
      logic wr_opnd;
      logic wr_stat;
      logic wr_set;
      logic wr_clr;
   } wr_strb_t;
endpackage

// File: rtl/fcp_decode.sv
module fcp_decode
   import fcp_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_be,
   output wr_strb_t          wr_strb,
   output logic              rd_strb,
   output rd_sel_t           rd_sel
);
   localparam int unsigned HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

   logic       full_word;
   logic       high_zero;
   logic [7:0] ofs;

   assign full_word = (req_be == 4'hF);

   generate
      if (ADDR_W > 8) begin : g_wide
         logic [HI_W-1:0] hi;
         assign hi        = req_addr[ADDR_W-1:8];
         assign high_zero = (hi == '0);
         assign ofs       = req_addr[7:0];
      end else begin : g_narrow
         assign high_zero = 1'b1;
         assign ofs       = 8'(req_addr);
      end
   endgenerate

   logic wr_ok;
   assign wr_ok = req_valid && req_write && full_word && high_zero;
   assign rd_strb = req_valid && !req_write;

   always_comb begin
      wr_strb         = '0;
      wr_strb.wr_live = wr_ok && (ofs == OFS_LIVE);
      wr_strb.wr_opnd = wr_ok && (ofs == OFS_OPND);
      wr_strb.wr_stat = wr_ok && (ofs == OFS_STAT);
      wr_strb.wr_set  = wr_ok && (ofs == OFS_SET);
      wr_strb.wr_clr  = wr_ok && (ofs == OFS_CLR);
   end

   always_comb begin
      rd_sel = RS_NONE;
      if (full_word && high_zero) begin
         unique case (ofs)
            OFS_ID:   rd_sel = RS_ID;
            OFS_LIVE: rd_sel = RS_LIVE;
            OFS_OPND: rd_sel = RS_OPND;
            OFS_STAT: rd_sel = RS_STAT;
            OFS_IRQ:  rd_sel = RS_IRQ;
            default:  rd_sel = RS_NONE;
         endcase
      end
   end
endmodule

// File: rtl/fcp_fact_engine.sv
module fcp_fact_engine #(
   parameter int unsigned W         = 32,
   parameter bit          ZERO_EXIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] operand,
   output logic         busy,
   output logic [W-1:0] value,
   output logic         done
);
   logic [W-1:0] cnt_q;
   logic [W-1:0] prod_q;
   logic [W-1:0] prod_nx;
   logic         finish;

   assign prod_nx = prod_q * cnt_q;

   generate
      if (ZERO_EXIT) begin : g_zero_exit
         assign finish = busy && ((cnt_q == '0) || (prod_q == '0));
      end else begin : g_full_run
         assign finish = busy && (cnt_q == '0);
      end
   endgenerate

   assign done = finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         value  <= '0;
         cnt_q  <= '0;
         prod_q <= '0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         value  <= operand;
         cnt_q  <= operand;
         prod_q <= W'(1);
      end else if (finish) begin
         busy  <= 1'b0;
         value <= prod_q;
      end else if (busy) begin
         prod_q <= prod_nx;
         cnt_q  <= cnt_q - W'(1);
      end
   end
endmodule

// File: rtl/fcp_irq_reg.sv
module fcp_irq_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_mask,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] status,
   output logic         irq
);
   logic [W-1:0] status_nx;

   assign status_nx = (status & ~clr_mask) | set_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= status_nx;
   end

   assign irq = |status;
endmodule

// File: rtl/fact_copro.sv
module fact_copro
   import fcp_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter bit          ZERO_EXIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] ext_raise,
   output logic              irq
);
   initial begin
      assert (DATA_W == WORD_W) else $error("DATA_W must be %0d", WORD_W);
      assert (ADDR_W >= 7) else $error("ADDR_W too small for the map");
   end

   wr_strb_t          wr_strb;
   logic              rd_strb;
   rd_sel_t           rd_sel;
   logic              eng_busy;
   logic              eng_done;
   logic [DATA_W-1:0] eng_value;
   logic              fact_en;
   logic [DATA_W-1:0] live_q;
   logic [DATA_W-1:0] irq_stat;
   logic [DATA_W-1:0] set_mask;
   logic [DATA_W-1:0] clr_mask;
   logic [DATA_W-1:0] fact_raise;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] rd_next;

   fcp_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .wr_strb   (wr_strb),
      .rd_strb   (rd_strb),
      .rd_sel    (rd_sel)
   );

   fcp_fact_engine #(.W(DATA_W), .ZERO_EXIT(ZERO_EXIT)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (wr_strb.wr_opnd),
      .operand (req_wdata),
      .busy    (eng_busy),
      .value   (eng_value),
      .done    (eng_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q  <= '0;
         fact_en <= 1'b0;
      end else begin
         if (wr_strb.wr_live) live_q  <= ~req_wdata;
         if (wr_strb.wr_stat) fact_en <= req_wdata[EN_BIT];
      end
   end

   always_comb begin
      fact_raise = '0;
      fact_raise[FACT_IRQ_BIT] = eng_done && fact_en;
   end

   assign set_mask = (wr_strb.wr_set ? req_wdata : '0) | ext_raise | fact_raise;
   assign clr_mask = wr_strb.wr_clr ? req_wdata : '0;

   fcp_irq_reg #(.W(DATA_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .status   (irq_stat),
      .irq      (irq)
   );

   always_comb begin
      stat_word = '0;
      stat_word[BUSY_BIT] = eng_busy;
      stat_word[EN_BIT]   = fact_en;
   end

   always_comb begin
      unique case (rd_sel)
         RS_ID:   rd_next = ID_WORD;
         RS_LIVE: rd_next = live_q;
         RS_OPND: rd_next = eng_value;
         RS_STAT: rd_next = stat_word;
         RS_IRQ:  rd_next = irq_stat;
         default: rd_next = '1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data <= '0;
      else if (rd_strb) rd_data <= rd_next;
   end
endmodule

// File: rtl/fcp_checker.sv
module fcp_checker #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [3:0]        req_be,
   input logic [DATA_W-1:0] req_wdata,
   input logic [DATA_W-1:0] ext_raise,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq,
   input logic              eng_busy,
   input logic              eng_done,
   input logic [DATA_W-1:0] eng_value,
   input logic              fact_en,
   input logic [DATA_W-1:0] live_q,
   input logic [DATA_W-1:0] irq_stat
);
   logic is_rd, is_wr, full;
   assign is_rd = req_valid && !req_write;
   assign is_wr = req_valid && req_write;
   assign full  = (req_be == 4'hF);

   AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd && full && (req_addr == ADDR_W'(8'h00)) |=> rd_data == 32'h010000ED); // R1

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr && full && (req_addr == ADDR_W'(8'h08)) && eng_busy && !eng_done
      |=> $stable(eng_value)); // R3

   AST_OPND_START: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr && full && (req_addr == ADDR_W'(8'h08)) && !eng_busy |=> eng_busy); // R3

   AST_FACT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done && fact_en |=> irq_stat[0]); // R6

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr && full && (req_addr == ADDR_W'(8'h64)) && (req_wdata == '1)
      && (ext_raise == '0) && !eng_done |=> !irq); // R8

   AST_PART_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr && !full && (ext_raise == '0) && !eng_done
      |=> $stable(live_q) && $stable(irq_stat) && $stable(fact_en)); // R9

   AST_PART_READ: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd && !full |=> rd_data == '1); // R9

   AST_RAISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ext_raise[8] |=> irq_stat[8]); // R10
endmodule

bind fact_copro fcp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_be    (req_be),
   .req_wdata (req_wdata),
   .ext_raise (ext_raise),
   .rd_data   (rd_data),
   .irq       (irq),
   .eng_busy  (eng_busy),
   .eng_done  (eng_done),
   .eng_value (eng_value),
   .fact_en   (fact_en),
   .live_q    (live_q),
   .irq_stat  (irq_stat)
);

// File: tb/tb_fact_copro.sv
`timescale 1ns/1ps
module tb_fact_copro;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0]    req_be = 4'hF;
   logic [31:0]   req_wdata = '0;
   logic [31:0]   rd_data;
   logic [31:0]   ext_raise = '0;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   fact_copro #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rd_data(rd_data), .ext_raise(ext_raise), .irq(irq)
   );

   // {enable, operand, expected result}
   localparam logic [64:0] VEC [10] = '{
      {1'b1, 32'd0,  32'd1},
      {1'b0, 32'd1,  32'd1},
      {1'b1, 32'd2,  32'd2},
      {1'b1, 32'd3,  32'd6},
      {1'b0, 32'd5,  32'd120},
      {1'b1, 32'd10, 32'h00375F00},
      {1'b1, 32'd12, 32'h1C8CFC00},
      {1'b0, 32'd13, 32'h7328CC00},
      {1'b1, 32'd20, 32'h82B40000},
      {1'b1, 32'd40, 32'h00000000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d; req_be = be;
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_be = be;
      @(posedge clk); #1;
      d = rd_data;
      req_valid = 1'b0; req_be = 4'hF;
   endtask

   task automatic wait_idle(output logic [31:0] st);
      st = 32'h1;
      for (int i = 0; i < 100 && st[0]; i++) bus_read(8'h20, 4'hF, st);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] st;
      do_reset();

      // R11 reset state
      bus_read(8'h24, 4'hF, v); check("R11 irq status", v, 32'h0);
      check("R11 irq line", {31'b0, irq}, 32'h0);
      bus_read(8'h04, 4'hF, v); check("R11 live", v, 32'h0);
      bus_read(8'h20, 4'hF, v); check("R11 status", v, 32'h0);
      bus_read(8'h08, 4'hF, v); check("R11 operand", v, 32'h0);

      // R1 identifier
      bus_read(8'h00, 4'hF, v); check("R1 id", v, 32'h010000ED);

      // R2 liveness
      bus_write(8'h04, 32'h12345678, 4'hF);
      bus_read(8'h04, 4'hF, v); check("R2 live a", v, 32'hEDCBA987);
      bus_write(8'h04, 32'h0, 4'hF);
      bus_read(8'h04, 4'hF, v); check("R2 live b", v, 32'hFFFFFFFF);

      // R5 status writes: only bit 7 sticks
      bus_write(8'h20, 32'hFFFFFFFF, 4'hF);
      bus_read(8'h20, 4'hF, v); check("R5 enable set", v, 32'h80);
      bus_write(8'h20, 32'h7F, 4'hF);
      bus_read(8'h20, 4'hF, v); check("R5 enable clear", v, 32'h0);

      // R3 R4 R6 R8 vector walk
      foreach (VEC[i]) begin
         bus_write(8'h20, VEC[i][64] ? 32'h80 : 32'h0, 4'hF);
         bus_write(8'h08, VEC[i][63:32], 4'hF);
         bus_read(8'h20, 4'hF, v); check("R3 busy set", {31'b0, v[0]}, 32'h1);
         wait_idle(st); check("R4 busy clear", {31'b0, st[0]}, 32'h0);
         bus_read(8'h08, 4'hF, v); check("R4 result", v, VEC[i][31:0]);
         bus_read(8'h24, 4'hF, v); check("R6 fact irq bit", v, {31'b0, VEC[i][64]});
         check("R8 line follows", {31'b0, irq}, {31'b0, VEC[i][64]});
         bus_write(8'h64, 32'hFFFFFFFF, 4'hF);
         check("R8 line low", {31'b0, irq}, 32'h0);
      end

      // R3 write while busy ignored
      bus_write(8'h20, 32'h0, 4'hF);
      bus_write(8'h08, 32'd10, 4'hF);
      bus_write(8'h08, 32'd3, 4'hF);
      wait_idle(st);
      bus_read(8'h08, 4'hF, v); check("R3 ignore busy write", v, 32'h00375F00);

      // R7 R8 set and clear
      bus_write(8'h60, 32'h00F00005, 4'hF);
      bus_read(8'h24, 4'hF, v); check("R7 set", v, 32'h00F00005);
      check("R8 line high", {31'b0, irq}, 32'h1);
      bus_write(8'h60, 32'h00000002, 4'hF);
      bus_read(8'h24, 4'hF, v); check("R7 set or", v, 32'h00F00007);
      bus_write(8'h64, 32'h00000004, 4'hF);
      bus_read(8'h24, 4'hF, v); check("R7 clear", v, 32'h00F00003);
      bus_write(8'h64, 32'h00F00003, 4'hF);
      bus_read(8'h24, 4'hF, v); check("R7 clear all", v, 32'h0);
      check("R8 line drops", {31'b0, irq}, 32'h0);

      // R9 partial and unmapped accesses
      bus_write(8'h04, 32'hA5A5A5A5, 4'hF);
      bus_write(8'h04, 32'h0, 4'h3);
      bus_read(8'h04, 4'hF, v); check("R9 partial write live", v, 32'h5A5A5A5A);
      bus_write(8'h60, 32'hFFFFFFFF, 4'h7);
      bus_read(8'h24, 4'hF, v); check("R9 partial write set", v, 32'h0);
      bus_read(8'h00, 4'h1, v); check("R9 partial read", v, 32'hFFFFFFFF);
      bus_read(8'h40, 4'hF, v); check("R9 unmapped read", v, 32'hFFFFFFFF);
      bus_read(8'h05, 4'hF, v); check("R9 unaligned read", v, 32'hFFFFFFFF);

      // R10 raise input wins over same-cycle clear
      bus_write(8'h60, 32'h00000100, 4'hF);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(8'h64);
      req_wdata = 32'h00000101; req_be = 4'hF; ext_raise = 32'h00000100;
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0; ext_raise = '0;
      bus_read(8'h24, 4'hF, v); check("R10 raise beats clear", v, 32'h00000100);
      @(negedge clk); ext_raise = 32'h00010000;
      @(posedge clk); #1; ext_raise = '0;
      bus_read(8'h24, 4'hF, v); check("R10 raise or", v, 32'h00010100);

      // R11 reset mid-state
      bus_write(8'h20, 32'h80, 4'hF);
      bus_write(8'h08, 32'd12, 4'hF);
      do_reset();
      check("R11 line after reset", {31'b0, irq}, 32'h0);
      bus_read(8'h24, 4'hF, v); check("R11 irq cleared", v, 32'h0);
      bus_read(8'h20, 4'hF, v); check("R11 status cleared", v, 32'h0);
      bus_read(8'h08, 4'hF, v); check("R11 operand cleared", v, 32'h0);
      bus_read(8'h04, 4'hF, v); check("R11 live cleared", v, 32'h0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule